// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block collects a set of interrupt request lines, gives each one a priority chosen by software, and presents to the processor the most urgent pending request. A request is offered only when its priority is strictly above the level the processor is currently running at. Each source has a fixed 9-bit vector equal to its index, so the handler can be chosen without a search. The processor takes the vector either by pulsing a hardware acknowledge or by reading the vector register. Taking the vector saves the running level on an internal last-in-first-out stack, raises the running level to the served source's priority, and clears that source's pending flag. A write to the end-of-interrupt register restores the saved level.

Software may also write the running level directly. Raising it to the highest priority among the tasks that share a resource keeps those tasks from preempting one another, which is the priority ceiling protocol. The request output and its vector are registered. They follow any change of pending flags, priorities or running level one clock later.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, irq_o is low, the running level is 0, every source priority is 0, and a vector register read returns 0x1FF.
- R2: A rising edge on a source line sets that source's pending flag. The flag stays set until the source is served. A line that stays high after service does not set it again.
- R3: A source whose priority is 0 never wins. Giving a source that is already pending a nonzero priority makes it eligible.
- R4: Among pending sources with nonzero priority, the one with the highest priority wins, and ties go to the lowest index. vec_o carries the winner's index as a 9-bit value.
- R5: irq_o is high only when the winning priority is strictly greater than the running level. An equal or lower priority is held back.
- R6: irq_o and vec_o are registered. They reflect a change of pending flags, priorities or running level on the clock edge after that change takes effect.
- R7: An acknowledge takes the vector. It is either ack_i or a read of address 1, in a cycle where irq_o is high. It pushes the running level onto the stack, sets the running level to the winner's priority, and clears the winner's pending flag. irq_o is low in the following cycle.
- R8: A read of address 1 while irq_o is low returns 0x1FF and changes no state.
- R9: A write to address 2 (end of interrupt, data ignored) pops the stack into the running level. With an empty stack it leaves the running level unchanged.
- R10: Address 0 holds the running level in bits [3:0]. Software can read and write it, and a write re-arbitrates against the new level.
- R11: Register map: address 4+i holds the priority of source i in bits [3:0] (read/write). Address 1 returns the vector in bits [8:0]. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | NSRC | Interrupt request lines, rising edge sets pending |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 9 | Vector of the offered source, valid while irq_o is high |
| ack_i | input | 1 | Hardware acknowledge of the offered vector |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (read of address 1 acknowledges) |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 4 | Register write data |
| bus_rdata | output | 9 | Register read data, combinational from bus_addr |

## Verification
A running level that is wrong shows up at the ports. It either holds back a request that should preempt or lets an equal priority through. That is visible on irq_o within two clocks of the request edge, and on the level readback at address 0. Stack corruption appears only at end of interrupt, when the restored level read back after the pop differs from the level saved at the matching acknowledge. A pending flag that is not cleared, or that is set again, re-raises irq_o with a vector already served. The scoreboard catches that on the next acknowledge.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int PRIO_W = 4;
    localparam int VEC_W  = 9;

    // register offsets
    localparam int A_CUR  = 0;
    localparam int A_VEC  = 1;
    localparam int A_EOI  = 2;
    localparam int A_PRI0 = 4;

    localparam logic [VEC_W-1:0] NO_VEC = '1;

    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
        logic [VEC_W-1:0]  vec;
    } win_t;

    function automatic logic beats(input win_t w, input logic [PRIO_W-1:0] lvl);
        return w.valid && (w.prio > lvl);
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] src_d;
    logic [N-1:0] rise;

    assign rise = src & ~src_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_d <= '0;
            pend  <= '0;
        end else begin
            src_d <= src;
            pend  <= (pend & ~clr) | rise;
        end
    end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import prio_irq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]             pend,
    input  logic [N-1:0][PRIO_W-1:0] prio,
    output win_t                     win
);
    always_comb begin
        win = '0;
        for (int i = 0; i < N; i++) begin
            // strict compare keeps the lowest index on ties; prio 0 never exceeds 0
            if (pend[i] && (prio[i] > win.prio)) begin
                win.valid = 1'b1;
                win.prio  = prio[i];
                win.vec   = VEC_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
    import prio_irq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [PRIO_W-1:0] din,
    output logic [PRIO_W-1:0] top,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [PRIO_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cnt;

    assign empty = (cnt == '0);
    assign top   = empty ? '0 : mem[PTR_W'(cnt - 1'b1)];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (push) begin
            if (cnt < CNT_W'(DEPTH)) begin
                mem[PTR_W'(cnt)] <= din;
                cnt              <= cnt + 1'b1;
            end
        end else if (pop && !empty) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NSRC        = 8,
    parameter int STACK_DEPTH = 16,
    parameter int ADDR_W      = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   irq_src_i,
    output logic              irq_o,
    output logic [VEC_W-1:0]  vec_o,
    input  logic              ack_i,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PRIO_W-1:0] bus_wdata,
    output logic [VEC_W-1:0]  bus_rdata
);
    logic [NSRC-1:0][PRIO_W-1:0] prio_tbl;
    logic [PRIO_W-1:0]           cur_q;
    logic                        irq_q;
    win_t                        win, win_q;
    logic [NSRC-1:0]             pend, clr;
    logic                        vec_rd, take, eoi, cur_wr;
    logic [PRIO_W-1:0]           stk_top;
    logic                        stk_empty;

    assign vec_rd = bus_re && (bus_addr == ADDR_W'(A_VEC));
    assign take   = irq_q && (ack_i || vec_rd);
    assign eoi    = bus_we && (bus_addr == ADDR_W'(A_EOI));
    assign cur_wr = bus_we && (bus_addr == ADDR_W'(A_CUR));
    assign clr    = take ? (NSRC'(1) << win_q.vec) : '0;

    irq_pend_bank #(.N(NSRC)) u_pend (
        .clk  (clk),
        .rst  (rst),
        .src  (irq_src_i),
        .clr  (clr),
        .pend (pend)
    );

    irq_prio_arb #(.N(NSRC)) u_arb (
        .pend (pend),
        .prio (prio_tbl),
        .win  (win)
    );

    irq_lvl_stack #(.DEPTH(STACK_DEPTH)) u_stk (
        .clk   (clk),
        .rst   (rst),
        .push  (take),
        .pop   (eoi && !take),
        .din   (cur_q),
        .top   (stk_top),
        .empty (stk_empty)
    );

    // running level: acknowledge first, then end of interrupt, then software write
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else if (take) begin
            cur_q <= win_q.prio;
        end else if (eoi && !stk_empty) begin
            cur_q <= stk_top;
        end else if (cur_wr) begin
            cur_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_tbl <= '0;
        end else begin
            for (int i = 0; i < NSRC; i++) begin
                if (bus_we && (bus_addr == ADDR_W'(A_PRI0 + i)))
                    prio_tbl[i] <= bus_wdata;
            end
        end
    end

    // registered request and vector
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            win_q <= '0;
        end else begin
            irq_q <= take ? 1'b0 : beats(win, cur_q);
            win_q <= win;
        end
    end

    assign irq_o = irq_q;
    assign vec_o = win_q.vec;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_CUR))
            bus_rdata = VEC_W'(cur_q);
        else if (bus_addr == ADDR_W'(A_VEC))
            bus_rdata = irq_q ? win_q.vec : NO_VEC;
        else begin
            for (int i = 0; i < NSRC; i++) begin
                if (bus_addr == ADDR_W'(A_PRI0 + i))
                    bus_rdata = VEC_W'(prio_tbl[i]);
            end
        end
    end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk
    import prio_irq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              irq_o,
    input logic              ack_i,
    input logic              bus_re,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [VEC_W-1:0]  bus_rdata,
    input logic [PRIO_W-1:0] cur_q,
    input logic [PRIO_W-1:0] win_prio,
    input logic              stk_empty
);
    logic take_s, eoi_s, vrd_s;
    assign vrd_s  = bus_re && (bus_addr == ADDR_W'(A_VEC));
    assign take_s = irq_o && (ack_i || vrd_s);
    assign eoi_s  = bus_we && (bus_addr == ADDR_W'(A_EOI));

    // R5
    strict_preempt_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (win_prio > $past(cur_q)));

    // R3
    no_zero_prio_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (win_prio != '0));

    // R7
    ack_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
        take_s |=> !irq_o);

    // R7
    ack_raises_lvl_chk: assert property (@(posedge clk) disable iff (rst)
        take_s |=> (cur_q == $past(win_prio)));

    // R9
    eoi_empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_s && !take_s && stk_empty) |=> $stable(cur_q));

    // R8
    idle_vec_read_chk: assert property (@(posedge clk) disable iff (rst)
        (vrd_s && !irq_o) |-> (bus_rdata == NO_VEC));
endmodule

bind prio_irq_ctrl prio_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_o     (irq_o),
    .ack_i     (ack_i),
    .bus_re    (bus_re),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .cur_q     (cur_q),
    .win_prio  (win_q.prio),
    .stk_empty (stk_empty)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    localparam int NSRC = 8;
    localparam int AW   = 6;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NSRC-1:0] src = '0;
    logic           irq_o;
    logic [8:0]     vec_o;
    logic           ack_i = 1'b0;
    logic           bus_we = 1'b0;
    logic           bus_re = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [3:0]     bus_wdata = '0;
    logic [8:0]     bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int exp_q[$];

    always #2 clk = ~clk;

    prio_irq_ctrl #(.NSRC(NSRC), .STACK_DEPTH(16), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .irq_src_i(src), .irq_o(irq_o), .vec_o(vec_o),
        .ack_i(ack_i), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = 4'(d);
        settle(1);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        bus_re = 1'b1; bus_addr = AW'(a);
        #1 d = int'(bus_rdata);
        settle(1);
        bus_re = 1'b0;
    endtask

    task automatic hw_ack(input int exp_vec);
        exp_q.push_back(exp_vec);
        ack_i = 1'b1;
        settle(1);
        ack_i = 1'b0;
    endtask

    task automatic sw_ack(input int exp_vec);
        int d;
        exp_q.push_back(exp_vec);
        rd(1, d);
    endtask

    task automatic chk_cur(input string req, input int exp);
        int d;
        rd(0, d);
        check(d == exp, req, d, exp);
    endtask

    task automatic chk_irq(input string req, input bit exp);
        check(irq_o == exp, req, int'(irq_o), int'(exp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // monitor: every acknowledge is compared against the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (irq_o && (ack_i || (bus_re && bus_addr == AW'(1)))) begin
                int got;
                got = ack_i ? int'(vec_o) : int'(bus_rdata);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected ack", got, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(got == e, "R4 vector", got, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int d;
        settle(3);
        rst = 1'b0;
        settle(1);

        // R1 reset state
        chk_irq("R1 irq", 1'b0);
        chk_cur("R1 level", 0);
        rd(4 + 4, d); check(d == 0, "R1 prio", d, 0);
        rd(1, d);     check(d == 'h1FF, "R1 vec", d, 'h1FF);
        chk_cur("R8 no side effect", 0);

        // program priorities
        wr(4 + 0, 3); wr(4 + 1, 5); wr(4 + 2, 5);
        wr(4 + 3, 0); wr(4 + 4, 9); wr(4 + 5, 2);
        rd(4 + 4, d); check(d == 9, "R11 prio readback", d, 9);
        rd(3, d);     check(d == 0, "R11 unmapped", d, 0);

        // R3 disabled source
        src[3] = 1'b1;
        settle(3);
        chk_irq("R3 prio0 ignored", 1'b0);

        // R4 tie, R6 latency
        src[1] = 1'b1; src[2] = 1'b1;
        settle(1);
        chk_irq("R6 not yet", 1'b0);
        settle(1);
        chk_irq("R4 irq", 1'b1);
        check(vec_o == 9'd1, "R4 tie low index", int'(vec_o), 1);
        hw_ack(1);
        chk_irq("R7 irq drops", 1'b0);
        chk_cur("R7 level raised", 5);

        // R5 lower and equal held back
        src[0] = 1'b1;
        settle(3);
        chk_irq("R5 held back", 1'b0);

        // preemption by higher, software acknowledge
        src[4] = 1'b1;
        settle(2);
        chk_irq("R5 preempt", 1'b1);
        check(vec_o == 9'd4, "R4 highest wins", int'(vec_o), 4);
        sw_ack(4);
        chk_cur("R7 sw ack level", 9);

        // R9 unwind
        wr(2, 0);
        chk_cur("R9 pop", 5);
        settle(2);
        chk_irq("R5 equal blocked", 1'b0);
        wr(2, 0);
        chk_cur("R9 pop to base", 0);
        settle(1);
        chk_irq("R4 src2 offered", 1'b1);
        check(vec_o == 9'd2, "R4 src2", int'(vec_o), 2);
        hw_ack(2);
        chk_cur("R7 level", 5);
        wr(2, 0);
        settle(1);
        chk_irq("R4 src0 offered", 1'b1);
        check(vec_o == 9'd0, "R4 src0", int'(vec_o), 0);
        hw_ack(0);
        chk_cur("R7 level", 3);
        wr(2, 0);
        chk_cur("R9 pop", 0);

        // R9 empty stack
        wr(0, 6);
        wr(2, 0);
        chk_cur("R9 empty keeps level", 6);

        // R10 ceiling
        src[1] = 1'b0; settle(1);
        src[1] = 1'b1;
        settle(3);
        chk_irq("R10 ceiling blocks", 1'b0);
        wr(0, 4);
        chk_irq("R6 one cycle after write", 1'b0);
        settle(1);
        chk_irq("R10 lowered ceiling", 1'b1);
        check(vec_o == 9'd1, "R10 vec", int'(vec_o), 1);
        hw_ack(1);
        chk_cur("R7 level", 5);
        wr(2, 0);
        chk_cur("R9 restore ceiling", 4);

        // R2 held line does not pend again
        settle(3);
        chk_irq("R2 held level", 1'b0);

        // R3 enabling a pending source
        wr(4 + 3, 7);
        settle(1);
        chk_irq("R3 enabled", 1'b1);
        check(vec_o == 9'd3, "R3 vec", int'(vec_o), 3);
        hw_ack(3);
        chk_cur("R7 level", 7);
        wr(2, 0);
        chk_cur("R9 pop", 4);

        // R8 idle vector read
        settle(2);
        rd(1, d); check(d == 'h1FF, "R8 idle read", d, 'h1FF);
        chk_cur("R8 level unchanged", 4);

        check(exp_q.size() == 0, "R7 all acks seen", exp_q.size(), 0);
        finish_run();
    end
endmodule